// File: doc/BRIEF.md
# EPROM Programming Pulse Sequencer

This block times the programming strobe for a single EPROM location. A one-cycle start strobe launches a burst of active-low program pulses on `prog_n_o`. Each pulse is a fixed number of microseconds long and is followed by a fixed high gap. The number of pulses in the burst depends on the algorithm chosen at start.

The fast algorithm drives a short burst. While that burst runs, the block holds an extra control line high, because parts programmed this way need that signal. The legacy algorithm drives a longer burst and leaves the control line low. Older devices must always be programmed with the legacy count, so the system selects it for them through the mode input.

Pulse and gap lengths are cycle counts derived from the clock frequency parameter. The block raises `busy_o` for the whole burst and gives a one-cycle `done_o` when the burst ends.

Top module: `eprom_pulse_seq`

## Requirements
- R1: After reset `prog_n_o` is high, and `busy_o`, `done_o` and `mode_ctl_o` are low.
- R2: A start taken with `fast_mode_i` = 1 produces exactly FAST_PULSES low pulses, 5 by default.
- R3: A start taken with `fast_mode_i` = 0 produces exactly LEGACY_PULSES low pulses, 25 by default.
- R4: Every low pulse on `prog_n_o` lasts PULSE_US microseconds, which is (CLK_FREQ_HZ/1e6)*PULSE_US clock cycles.
- R5: Each pulse, including the last, is followed by a high gap of GAP_US microseconds, which is (CLK_FREQ_HZ/1e6)*GAP_US cycles.
- R6: `mode_ctl_o` is high on every cycle of a fast-mode burst. It is low during a legacy burst and while idle.
- R7: `busy_o` rises on the cycle after start is sampled and the first pulse begins on that same cycle. `busy_o` stays high for exactly N*(pulse+gap) cycles, where N is the pulse count for the mode.
- R8: `done_o` is high for exactly one cycle, on the first cycle that `busy_o` is low after a burst.
- R9: A start received while busy is ignored: pulse count, burst length and `mode_ctl_o` are unchanged.
- R10: The mode is sampled only at start. Changing `fast_mode_i` during a burst changes neither the pulse count nor `mode_ctl_o`.
- R11: `prog_n_o` is low only while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_FREQ_HZ |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| fast_mode_i | input | 1 | 1 selects the short burst, 0 selects the legacy burst |
| prog_n_o | output | 1 | Active-low program pulse |
| mode_ctl_o | output | 1 | Extra control line, high throughout a fast burst |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle end-of-burst flag |

## Verification
The hardest situation to reach from the ports is a second start, or a mode change, that arrives in the middle of a burst. It must leave the rest of the sequence untouched. The stimulus gets there by having the burst task count sampled cycles and inject the stray strobe at a chosen cycle: inside a pulse in one run and inside a gap in another. The same cycle also flips `fast_mode_i`. The task then measures every low run, every gap, the total busy time and the done pulse as if no disturbance had happened.

// File: rtl/eprom_pulse_pkg.sv
package eprom_pulse_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_GAP   = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       fast;
        logic       prog_n;
        logic       mode_ctl;
        logic       done;
    } seq_regs_t;

endpackage

// File: rtl/eprom_pulse_timer.sv
module eprom_pulse_timer #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    output logic             expired_o
);
    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/eprom_pulse_tally.sv
module eprom_pulse_tally #(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic [WIDTH-1:0] target_i,
    output logic             last_o
);
    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (inc_i)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == target_i);
endmodule

// File: rtl/eprom_pulse_seq.sv
module eprom_pulse_seq
    import eprom_pulse_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ   = 250_000_000,
    parameter int unsigned PULSE_US      = 100,
    parameter int unsigned GAP_US        = 10,
    parameter int unsigned FAST_PULSES   = 5,
    parameter int unsigned LEGACY_PULSES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic fast_mode_i,
    output logic prog_n_o,
    output logic mode_ctl_o,
    output logic busy_o,
    output logic done_o
);
    localparam int unsigned CYC_PER_US = CLK_FREQ_HZ / 1_000_000;
    localparam int unsigned PULSE_CYC  = CYC_PER_US * PULSE_US;
    localparam int unsigned GAP_CYC    = CYC_PER_US * GAP_US;
    localparam int unsigned MAX_CYC    = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
    localparam int unsigned TMR_W      = $clog2(MAX_CYC + 1);
    localparam int unsigned MAX_PULSES = (FAST_PULSES > LEGACY_PULSES) ? FAST_PULSES : LEGACY_PULSES;
    localparam int unsigned CNT_W      = $clog2(MAX_PULSES + 1);
    localparam logic [TMR_W-1:0] PULSE_LOAD = TMR_W'(PULSE_CYC - 1);
    localparam logic [TMR_W-1:0] GAP_LOAD   = TMR_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] FAST_N     = CNT_W'(FAST_PULSES);
    localparam logic [CNT_W-1:0] LEGACY_N   = CNT_W'(LEGACY_PULSES);

    localparam seq_regs_t RESET_REGS = '{
        state:    ST_IDLE,
        fast:     1'b0,
        prog_n:   1'b1,
        mode_ctl: 1'b0,
        done:     1'b0
    };

    seq_regs_t        r_d, r_q;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             tally_clr;
    logic             tally_inc;
    logic [CNT_W-1:0] tally_target;
    logic             tally_last;

    eprom_pulse_timer #(.WIDTH(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    eprom_pulse_tally #(.WIDTH(CNT_W)) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (tally_clr),
        .inc_i    (tally_inc),
        .target_i (tally_target),
        .last_o   (tally_last)
    );

    assign tally_target = r_q.fast ? FAST_N : LEGACY_N;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = PULSE_LOAD;
        tally_clr = 1'b0;
        tally_inc = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_PULSE;
                    r_d.fast  = fast_mode_i;
                    tmr_load  = 1'b1;
                    tmr_val   = PULSE_LOAD;
                    tally_clr = 1'b1;
                end
            end
            ST_PULSE: begin
                if (tmr_expired) begin
                    r_d.state = ST_GAP;
                    tmr_load  = 1'b1;
                    tmr_val   = GAP_LOAD;
                    tally_inc = 1'b1;
                end
            end
            ST_GAP: begin
                if (tmr_expired) begin
                    if (tally_last) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.state = ST_PULSE;
                        tmr_load  = 1'b1;
                        tmr_val   = PULSE_LOAD;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        r_d.prog_n   = (r_d.state != ST_PULSE);
        r_d.mode_ctl = (r_d.state != ST_IDLE) && r_d.fast;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_REGS;
        else        r_q <= r_d;
    end

    assign prog_n_o   = r_q.prog_n;
    assign mode_ctl_o = r_q.mode_ctl;
    assign busy_o     = (r_q.state != ST_IDLE);
    assign done_o     = r_q.done;
endmodule

// File: rtl/eprom_pulse_seq_chk.sv
module eprom_pulse_seq_chk #(
    parameter int unsigned PULSE_CYC = 100,
    parameter int unsigned GAP_CYC   = 10
) (
    input logic clk,
    input logic rst_n,
    input logic fast_mode_i,
    input logic prog_n_o,
    input logic mode_ctl_o,
    input logic busy_o,
    input logic done_o
);
    logic [31:0] lo_cnt, hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
        end else begin
            lo_cnt <= prog_n_o ? 32'd0 : lo_cnt + 32'd1;
            hi_cnt <= (busy_o && prog_n_o) ? hi_cnt + 32'd1 : 32'd0;
        end
    end

    // R4
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_n_o && lo_cnt != 0) |-> (lo_cnt == PULSE_CYC));

    // R5
    gap_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_n_o && hi_cnt != 0) |-> (hi_cnt == GAP_CYC));

    // R5
    final_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (hi_cnt == GAP_CYC));

    // R11
    strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> busy_o);

    // R6
    mode_ctl_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ctl_o |-> busy_o);

    // R10
    mode_ctl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mode_ctl_o));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $fell(busy_o)));
endmodule

bind eprom_pulse_seq eprom_pulse_seq_chk #(
    .PULSE_CYC (PULSE_CYC),
    .GAP_CYC   (GAP_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fast_mode_i (fast_mode_i),
    .prog_n_o    (prog_n_o),
    .mode_ctl_o  (mode_ctl_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/eprom_pulse_seq_tb.sv
`timescale 1ns/1ps
module eprom_pulse_seq_tb;
    localparam int CLK_HZ = 1_000_000;
    localparam int P      = 100;
    localparam int G      = 10;
    localparam int NF     = 5;
    localparam int NL     = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic fast_mode_i = 1'b0;
    logic prog_n_o, mode_ctl_o, busy_o, done_o;
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    eprom_pulse_seq #(
        .CLK_FREQ_HZ(CLK_HZ), .PULSE_US(100), .GAP_US(10),
        .FAST_PULSES(NF), .LEGACY_PULSES(NL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .fast_mode_i(fast_mode_i),
        .prog_n_o(prog_n_o), .mode_ctl_o(mode_ctl_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_reset();
        chk(prog_n_o == 1'b1, "R1 prog_n", prog_n_o, 1);
        chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
        chk(done_o == 1'b0, "R1 done", done_o, 0);
        chk(mode_ctl_o == 1'b0, "R1 mode_ctl", mode_ctl_o, 0);
    endtask

    // Launch a burst; optionally inject a start plus a mode flip at busy cycle inject_at.
    task automatic run_burst(input bit fast, input int inject_at);
        int n_exp, pulses, busy_cyc, lo, hi, bad_lo, bad_hi, bad_mc, bad_prog;
        bit prev;
        n_exp = fast ? NF : NL;
        pulses = 0; busy_cyc = 0; lo = 0; hi = 0;
        bad_lo = 0; bad_hi = 0; bad_mc = 0; bad_prog = 0;
        prev = 1'b1;
        @(negedge clk);
        fast_mode_i = fast;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R7 busy after start", busy_o, 1);
        chk(prog_n_o == 1'b0, "R7 first pulse start", prog_n_o, 0);
        while (busy_o && busy_cyc < 5000) begin
            if (mode_ctl_o != fast) bad_mc++;
            if (!prog_n_o) begin
                if (prev) begin
                    pulses++;
                    if (pulses > 1 && hi != G) bad_hi++;
                end
                lo++; hi = 0;
            end else begin
                if (!prev && lo != P) bad_lo++;
                lo = 0; hi++;
            end
            prev = prog_n_o;
            busy_cyc++;
            if (busy_cyc == inject_at) begin
                start_i = 1'b1;
                fast_mode_i = ~fast;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        if (fast) chk(pulses == NF, "R2 fast pulse count", pulses, NF);
        else      chk(pulses == NL, "R3 legacy pulse count", pulses, NL);
        chk(bad_lo == 0, "R4 pulse width errors", bad_lo, 0);
        chk(bad_hi == 0 && hi == G, "R5 gap width", hi, G);
        chk(bad_mc == 0, "R6 mode_ctl during busy", bad_mc, 0);
        chk(busy_cyc == n_exp * (P + G), "R7 busy length", busy_cyc, n_exp * (P + G));
        chk(done_o == 1'b1, "R8 done at busy fall", done_o, 1);
        chk(prog_n_o == 1'b1, "R11 strobe high when idle", prog_n_o, 1);
        chk(mode_ctl_o == 1'b0, "R6 mode_ctl low when idle", mode_ctl_o, 0);
        if (inject_at > 0) begin
            chk(pulses == n_exp, "R9 R10 stray start/mode ignored", pulses, n_exp);
        end
        @(negedge clk);
        chk(done_o == 1'b0, "R8 done one cycle", done_o, 0);
        chk(busy_o == 1'b0, "R9 no restart from stray start", busy_o, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150_000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150_000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_reset();
        run_burst(1'b1, 0);
        run_burst(1'b0, 0);
        run_burst(1'b1, 50);
        run_burst(1'b0, 105);
        run_burst(1'b1, 215);
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0 && prog_n_o == 1'b1, "R11 idle after runs", busy_o, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule